// File: doc/BRIEF.md
# Flash Bank and Charge-Pump Sleep Sequencer

This block decides when a group of flash memory banks, and the charge pump they share, may leave the active state and when they must return to it. Each bank watches its own access strobe. Once the bank's fall-back mode is set to sleep, it counts idle cycles against a programmable grace period. It falls asleep only if that count runs out with no access. The shared pump follows only after every bank is asleep. Only when the pump and all banks are asleep does the block tell the clock controller that the system bus clock domain may be stopped.

Waking works in the opposite direction. A wake request, or an access to a sleeping bank, starts the pump's power-up delay. That delay is counted on a tick at half the bus clock rate, and it never falls below a floor that suits a 20 MHz bus clock. Banks that are waking return to active only after the pump reports active. While this happens, an access to a bank that is not usable raises that bank's wait line.

Top module: `flash_sleep_seq`

## Requirements
- R1: A bank whose fall-back input is 0 stays in ACTIVE, and a pump whose fall-back input is 0 never enters SLEEP. Unit state codes are ACTIVE=0, GRACE=1, SLEEP=2 and WAKING=3. Bank i's code sits at `bank_state[2i+1:2i]`.
- R2: A bank with fall-back set to sleep and grace value A>0 shows GRACE after its first idle sampled cycle. It shows SLEEP after A+1 consecutive idle sampled cycles.
- R3: An access seen while a bank is in GRACE returns it to ACTIVE. The next idle period starts the full count again.
- R4: The pump moves from ACTIVE to SLEEP one cycle after all banks show SLEEP, provided its fall-back is sleep and no wake request is present. It never does so while any bank is awake. `pump_ready` is 1 only when the pump is ACTIVE.
- R5: `clk_stop_ok` is 1 exactly when the pump and every bank show SLEEP.
- R6: On wake, the pump stays in WAKING for 2*D cycles, then shows ACTIVE. D is the power-up delay taken when the wake starts, counted at half the bus clock rate.
- R7: A programmed delay below the parameter floor `DLY_MIN` (default 20) is replaced by the floor.
- R8: An access to a bank in SLEEP or WAKING drives that bank's `acc_wait` bit high in the same cycle. The bank moves to WAKING one cycle later and returns to ACTIVE one cycle after the pump shows ACTIVE.
- R9: A grace value of 0 puts a bank to sleep after the first idle cycle sampled with fall-back set to sleep.
- R10: A one-cycle `wake_req` moves every sleeping bank to WAKING and the sleeping pump to WAKING on the next cycle.
- R11: After reset all banks and the pump are ACTIVE, `pump_ready` is 1 and `clk_stop_ok` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_acc | input | NUM_BANKS | Per-bank access strobe |
| bank_fb_sleep | input | NUM_BANKS | Per-bank fall-back mode, 1 = sleep |
| pump_fb_sleep | input | 1 | Pump fall-back mode, 1 = sleep |
| grace_cfg | input | NUM_BANKS*AGP_W | Per-bank grace period, bank i at bits [AGP_W*i +: AGP_W] |
| pump_dly | input | DLY_W | Pump power-up delay in half-rate ticks |
| wake_req | input | 1 | Wake request for all sleeping units |
| bank_state | output | 2*NUM_BANKS | Per-bank state code |
| pump_state | output | 2 | Pump state code |
| pump_ready | output | 1 | Pump is ACTIVE |
| acc_wait | output | NUM_BANKS | Access must stall, bank not usable |
| clk_stop_ok | output | 1 | System bus clock domain may be stopped |

## Verification
The bench targets the edges of the grace count. It checks that zero grace gives immediate sleep, that a nonzero value sleeps after exactly A+1 idle cycles, and that an access one cycle before expiry fully restarts the count. An off-by-one counter or a missing reload would show SLEEP one cycle early or late. It also checks that the pump holds off sleep while one bank is still in GRACE, and that clock-stop permission drops the cycle a bank starts waking. A pump that sleeps too early would raise permission while a bank can still be reached. The power-up delay is measured at both the floor and a raised value, so a full-rate counter, an ignored floor or a bank that goes active before the pump would all give the wrong cycle at which the state changes.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_GRACE  = 2'd1,
    ST_SLEEP  = 2'd2,
    ST_WAKING = 2'd3
  } unit_st_e;
endpackage

// File: rtl/fss_rst_sync.sv
module fss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/fss_bank.sv
module fss_bank
  import fss_pkg::*;
#(
  parameter int AGP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic             fb_sleep_i,
  input  logic [AGP_W-1:0] grace_i,
  input  logic             wake_i,
  input  logic             pump_act_i,
  output unit_st_e         st_o,
  output logic             wait_o
);
  localparam logic [AGP_W-1:0] ONE = AGP_W'(1);

  unit_st_e         cur_q, nxt;
  logic [AGP_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    nxt    = cur_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (cur_q)
      ST_ACTIVE: begin
        if (fb_sleep_i && !acc_i) begin
          if (grace_i == '0) begin
            nxt = ST_SLEEP;
          end else begin
            nxt    = ST_GRACE;
            cnt_d  = grace_i;
            cnt_en = 1'b1;
          end
        end
      end
      ST_GRACE: begin
        if (acc_i || !fb_sleep_i) begin
          nxt = ST_ACTIVE;
        end else if (cnt_q == ONE) begin
          nxt = ST_SLEEP;
        end else begin
          cnt_d  = cnt_q - ONE;
          cnt_en = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (acc_i || wake_i) nxt = ST_WAKING;
      end
      ST_WAKING: begin
        if (pump_act_i) nxt = ST_ACTIVE;
      end
      default: nxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= ST_ACTIVE;
    else        cur_q <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign st_o   = cur_q;
  assign wait_o = acc_i && (cur_q == ST_SLEEP || cur_q == ST_WAKING);

  // R1
  bank_fb_active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_ACTIVE && !fb_sleep_i) |=> (cur_q == ST_ACTIVE));

  // R3
  grace_access_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_GRACE && acc_i) |=> (cur_q == ST_ACTIVE));

  // R2
  grace_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_GRACE && cnt_q > ONE && !acc_i && fb_sleep_i) |=> (cur_q == ST_GRACE));

  // R8
  no_active_without_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_WAKING && !pump_act_i) |=> (cur_q != ST_ACTIVE));
endmodule

// File: rtl/fss_pump.sv
module fss_pump
  import fss_pkg::*;
#(
  parameter int DLY_W   = 8,
  parameter int DLY_MIN = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fb_sleep_i,
  input  logic             all_sleep_i,
  input  logic             wake_i,
  input  logic [DLY_W-1:0] dly_i,
  output unit_st_e         st_o
);
  localparam logic [DLY_W-1:0] FLOOR = DLY_W'(DLY_MIN);
  localparam logic [DLY_W-1:0] ONE   = DLY_W'(1);

  unit_st_e         cur_q, nxt;
  logic [DLY_W-1:0] cnt_q, cnt_d, eff_dly;
  logic             cnt_en;
  logic             ph_q, ph_d;

  assign eff_dly = (dly_i < FLOOR) ? FLOOR : dly_i;

  always_comb begin
    nxt    = cur_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    ph_d   = 1'b0;
    unique case (cur_q)
      ST_ACTIVE: begin
        if (fb_sleep_i && all_sleep_i && !wake_i) nxt = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (wake_i) begin
          nxt    = ST_WAKING;
          cnt_d  = eff_dly;
          cnt_en = 1'b1;
        end
      end
      ST_WAKING: begin
        ph_d = !ph_q;
        if (ph_q) begin
          if (cnt_q <= ONE) begin
            nxt = ST_ACTIVE;
          end else begin
            cnt_d  = cnt_q - ONE;
            cnt_en = 1'b1;
          end
        end
      end
      default: nxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= ST_ACTIVE;
      ph_q  <= 1'b0;
    end else begin
      cur_q <= nxt;
      ph_q  <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign st_o = cur_q;

  // R4
  pump_waits_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_ACTIVE && !all_sleep_i) |=> (cur_q != ST_SLEEP));

  // R1
  pump_fb_active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_ACTIVE && !fb_sleep_i) |=> (cur_q == ST_ACTIVE));

  // R6
  pump_delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_WAKING && cnt_q > ONE) |=> (cur_q == ST_WAKING));

  // R6
  pump_half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == ST_WAKING && !ph_q) |=> (cur_q == ST_WAKING));
endmodule

// File: rtl/flash_sleep_seq.sv
module flash_sleep_seq
  import fss_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int AGP_W     = 8,
  parameter int DLY_W     = 8,
  parameter int DLY_MIN   = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS-1:0]       bank_acc,
  input  logic [NUM_BANKS-1:0]       bank_fb_sleep,
  input  logic                       pump_fb_sleep,
  input  logic [NUM_BANKS*AGP_W-1:0] grace_cfg,
  input  logic [DLY_W-1:0]           pump_dly,
  input  logic                       wake_req,
  output logic [2*NUM_BANKS-1:0]     bank_state,
  output logic [1:0]                 pump_state,
  output logic                       pump_ready,
  output logic [NUM_BANKS-1:0]       acc_wait,
  output logic                       clk_stop_ok
);
  logic                 rst_sn;
  unit_st_e             pump_st;
  logic [NUM_BANKS-1:0] asleep, waking, awake;
  logic                 all_sleep, pump_wake, pump_act;

  fss_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign pump_act = (pump_st == ST_ACTIVE);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    unit_st_e st;

    fss_bank #(.AGP_W(AGP_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_sn),
      .acc_i      (bank_acc[i]),
      .fb_sleep_i (bank_fb_sleep[i]),
      .grace_i    (grace_cfg[AGP_W*i +: AGP_W]),
      .wake_i     (wake_req),
      .pump_act_i (pump_act),
      .st_o       (st),
      .wait_o     (acc_wait[i])
    );

    assign bank_state[2*i +: 2] = st;
    assign asleep[i] = (st == ST_SLEEP);
    assign waking[i] = (st == ST_WAKING);
    assign awake[i]  = (st == ST_ACTIVE) || (st == ST_GRACE);
  end

  assign all_sleep = &asleep;
  assign pump_wake = (|waking) || wake_req;

  fss_pump #(.DLY_W(DLY_W), .DLY_MIN(DLY_MIN)) u_pump (
    .clk         (clk),
    .rst_n       (rst_sn),
    .fb_sleep_i  (pump_fb_sleep),
    .all_sleep_i (all_sleep),
    .wake_i      (pump_wake),
    .dly_i       (pump_dly),
    .st_o        (pump_st)
  );

  assign pump_state  = pump_st;
  assign pump_ready  = pump_act;
  assign clk_stop_ok = (pump_st == ST_SLEEP) && all_sleep;

  // R4
  pump_sleep_banks_down_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (pump_st != ST_ACTIVE) |-> (awake == '0));

  // R5
  stop_implies_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    clk_stop_ok |=> (pump_st != ST_ACTIVE));
endmodule

// File: tb/flash_sleep_seq_bench.sv
module flash_sleep_seq_bench;
  localparam int NB = 4;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int K_BANK = 0, K_PUMP = 1, K_STOP = 2, K_WAIT = 3, K_RDY = 4;

  typedef struct {
    int          cyc;
    int          kind;
    logic [31:0] val;
    string       tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NB-1:0]    bank_acc, bank_fb_sleep, acc_wait;
  logic             pump_fb_sleep, wake_req, pump_ready, clk_stop_ok;
  logic [NB*AW-1:0] grace_cfg;
  logic [DW-1:0]    pump_dly;
  logic [2*NB-1:0]  bank_state;
  logic [1:0]       pump_state;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_sleep_seq u_flash_sleep_seq (
    .clk(clk), .rst_n(rst_n), .bank_acc(bank_acc), .bank_fb_sleep(bank_fb_sleep),
    .pump_fb_sleep(pump_fb_sleep), .grace_cfg(grace_cfg), .pump_dly(pump_dly),
    .wake_req(wake_req), .bank_state(bank_state), .pump_state(pump_state),
    .pump_ready(pump_ready), .acc_wait(acc_wait), .clk_stop_ok(clk_stop_ok)
  );

  function automatic logic [31:0] actual(int kind);
    case (kind)
      K_BANK:  return 32'(bank_state);
      K_PUMP:  return 32'(pump_state);
      K_STOP:  return 32'(clk_stop_ok);
      K_WAIT:  return 32'(acc_wait);
      default: return 32'(pump_ready);
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_at(int off, int kind, logic [31:0] val, string tag);
    exp_t e;
    e.cyc = cyc + off; e.kind = kind; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares every queued item due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc == cyc) begin
        logic [31:0] a;
        a = actual(q[i].kind);
        n_chk++;
        if (a !== q[i].val) begin
          n_fail++;
          $display("FAIL %s kind=%0d cycle=%0d actual=%0h expected=%0h",
                   q[i].tag, q[i].kind, cyc, a, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bank_acc = '0; bank_fb_sleep = '0; pump_fb_sleep = 1'b0;
    grace_cfg = '0; pump_dly = '0; wake_req = 1'b0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R11 reset state
    expect_at(0, K_BANK, 0, "R11");
    expect_at(0, K_PUMP, 0, "R11");
    expect_at(0, K_STOP, 0, "R11");
    expect_at(0, K_RDY, 1, "R11");
    // R1 fall-back active keeps banks active through idle cycles
    expect_at(5, K_BANK, 0, "R1");
    repeat (5) step();

    // grace values: b0=0, b1=3, b2=5, b3=2; bank 3 kept busy
    grace_cfg = {8'd2, 8'd5, 8'd3, 8'd0};
    bank_fb_sleep = 4'hF;
    bank_acc = 4'b1000;
    expect_at(1, K_BANK, 'h16, "R9");
    expect_at(3, K_BANK, 'h16, "R2");
    expect_at(4, K_BANK, 'h1A, "R2");
    expect_at(6, K_BANK, 'h2A, "R2");
    expect_at(6, K_PUMP, 0, "R1");
    expect_at(8, K_BANK, 'h6A, "R2");
    expect_at(10, K_BANK, 'h2A, "R3");
    expect_at(12, K_BANK, 'h6A, "R3");
    expect_at(13, K_BANK, 'hAA, "R3");
    expect_at(13, K_PUMP, 0, "R4");
    expect_at(13, K_STOP, 0, "R5");
    expect_at(14, K_PUMP, 2, "R4");
    expect_at(14, K_STOP, 1, "R5");
    expect_at(14, K_RDY, 0, "R4");
    repeat (7) step();
    bank_acc = 4'b0000;
    repeat (2) step();
    bank_acc = 4'b1000;          // access one cycle before grace expiry
    step();
    bank_acc = 4'b0000;
    pump_fb_sleep = 1'b1;
    repeat (5) step();

    // R8 / R7: access to sleeping bank 1, delay below floor (20)
    bank_acc = 4'b0010;
    pump_dly = 8'd0;
    expect_at(0, K_WAIT, 2, "R8");
    expect_at(0, K_STOP, 1, "R5");
    expect_at(1, K_BANK, 'hAE, "R8");
    expect_at(1, K_STOP, 0, "R5");
    expect_at(2, K_PUMP, 3, "R6");
    expect_at(41, K_PUMP, 3, "R7");
    expect_at(42, K_PUMP, 0, "R7");
    expect_at(42, K_WAIT, 2, "R8");
    expect_at(43, K_BANK, 'hA2, "R8");
    expect_at(43, K_WAIT, 0, "R8");
    repeat (43) step();
    bank_acc = 4'b0000;
    expect_at(4, K_BANK, 'hAA, "R2");
    expect_at(5, K_PUMP, 2, "R4");
    repeat (5) step();

    // R10 / R6: wake request with raised delay 30
    pump_dly = 8'd30;
    wake_req = 1'b1;
    expect_at(1, K_BANK, 'hFF, "R10");
    expect_at(1, K_PUMP, 3, "R10");
    expect_at(60, K_PUMP, 3, "R6");
    expect_at(61, K_PUMP, 0, "R6");
    expect_at(61, K_BANK, 'hFF, "R6");
    expect_at(62, K_BANK, 0, "R10");
    step();
    wake_req = 1'b0;
    repeat (63) step();

    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R11 pending actual=%0d expected=0", q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule